// File: doc/BRIEF.md
# Software standby entry controller

This block sequences a small microcontroller into and out of its software standby power mode. When the CPU signals that it has executed a wait instruction, the controller looks at three configuration bits: standby select, deep-standby select, and the oscillator-stop monitor enable. If all three permit it, the controller stops the CPU and peripheral clocks, then stops every oscillator and removes power from the domains chosen by three cut bits. If they do not permit it, the controller enters a lighter sleep state instead. In sleep only the CPU clock is held and the oscillators keep running.

While the block is in standby, the independent watchdog is stopped or kept counting. The choice depends on how the watchdog was started: an auto-started watchdog follows its option-byte stop bit, and a register-started one follows its control-register stop bit. An interrupt ends standby or sleep only if it is routed to the CPU, is individually enabled, and has a priority above the current CPU level. Wake-up restores power before the oscillators. It gives the clocks back only once the oscillator reports that it is stable.

A mode code and a one-cycle change pulse let the rest of the chip follow each step of the sequence.

Top module: `ssby_ctrl`

## Requirements
- R1: Mode codes are run=0, standby entry=1, standby=2 and wake-up=3. A wait strobe accepted in run mode moves the mode to 1 in the next cycle, and to 2 one cycle later, when standby select is 1, deep-standby select is 0 and the oscillator-stop monitor enable is 0.
- R2: An accepted wait strobe that fails the test of R1 sets the sleep status to 1 in the next cycle. In that case the mode stays 0, the oscillator enables stay high, the CPU clock enable goes low and the peripheral clock enable stays high.
- R3: In mode 1 the CPU and peripheral clock enables are 0 and all oscillator enables are 1. In mode 2, every clock and oscillator enable is 0.
- R4: In mode 2, power-cut output bit i follows cut-configuration bit i (bit 0 is code memory, bit 1 is the high-speed oscillator, bit 2 is the voltage detector), and the power-on-reset low-power select follows cut bit 2. In every other mode all these outputs are 0.
- R5: In mode 2, the watchdog run output is 0 when the selected stop bit is 1, and 1 when it is 0. The selected stop bit is the option-byte bit when the auto-start input is 1, and the control-register bit otherwise. In all other modes the watchdog run output is 1.
- R6: Every accepted wait strobe, whether it qualifies for standby or not, gives a one-cycle pulse on the interrupt-enable set output in the next cycle.
- R7: A source is a wake request when its request, CPU-routing and enable bits are all 1 and its priority is strictly greater than the CPU level. A wake request in mode 2 moves the mode to 3 in the next cycle, and a wake request while sleeping clears the sleep status in the next cycle.
- R8: In the first wake-up cycle, the power-cut outputs are 0 and the oscillator enables are still 0. From the second wake-up cycle the oscillator enables are 1. The mode returns to 0, with the clocks enabled, in the cycle after oscillator-stable is sampled high in the second wake-up cycle or a later one. Oscillator-stable is ignored in the first wake-up cycle.
- R9: The mode-change output is 1 in exactly the first cycle in which a new mode code is shown, and 0 in every other cycle.
- R10: A wait strobe is ignored outside mode 0 and while the sleep status is 1.
- R11: An active-low reset clears the controller at once to mode 0 with the clocks and oscillators enabled and nothing cut. After release, the sequencer reacts to inputs from the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_stb | input | 1 | Wait-instruction strobe from the CPU |
| stby_sel | input | 1 | Standby select bit |
| deep_sel | input | 1 | Deep-standby select bit |
| osc_mon_en | input | 1 | Oscillator-stop monitor enable |
| cut_cfg | input | 3 | Per-domain power-cut selection |
| iwdg_auto | input | 1 | Independent watchdog was auto-started |
| iwdg_opt_stop | input | 1 | Option-byte standby stop bit |
| iwdg_reg_stop | input | 1 | Control-register standby stop bit |
| irq_req | input | NSRC | Interrupt requests |
| irq_to_cpu | input | NSRC | Source routed to the CPU |
| irq_en | input | NSRC | Per-source enable |
| irq_prio | input | NSRC*PRIO_W | Per-source priority, source i at bits i*PRIO_W upward |
| cpu_ipl | input | PRIO_W | Current CPU priority level |
| osc_stable | input | 1 | Oscillator has settled |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | NOSC | Oscillator enables |
| pwr_cut | output | 3 | Power-cut requests per domain |
| por_lowpwr | output | 1 | Power-on-reset low-power select |
| iwdg_run | output | 1 | Independent watchdog count enable |
| gie_set | output | 1 | Pulse that sets the CPU interrupt-enable flag |
| sleep_st | output | 1 | Sleep status |
| mode | output | 2 | Current mode code |
| mode_chg | output | 1 | One-cycle pulse on a mode change |

## Verification
The entry decision is tried with each configuration that blocks standby in turn: standby select low, deep select high and monitor enable high. Each must lead to sleep, while the one permitted setting leads to standby, so the three terms of the qualification test are told apart. Wake is tried with sources that fail one condition each: priority equal to the CPU level, not enabled, or not routed to the CPU. A fully qualified source follows, which separates the strict priority comparison from the other gates. The watchdog and cut outputs are tried in standby under both start modes, with the two stop bits set opposite to each other so that a wrong selection shows. Oscillator-stable is tried both held low through wake-up and already high at wake-up, which checks that the clocks wait for it and that the first wake cycle ignores it.

// File: rtl/ssby_pkg.sv
package ssby_pkg;

  localparam int unsigned CUT_DOMAINS = 3;
  localparam int unsigned CUT_CODE    = 0;
  localparam int unsigned CUT_HSOSC   = 1;
  localparam int unsigned CUT_VDET    = 2;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_ENTRY = 3'd1,
    ST_STBY  = 3'd2,
    ST_WCUT  = 3'd3,
    ST_WOSC  = 3'd4
  } ssby_state_e;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_ENTRY = 2'd1,
    MODE_STBY  = 2'd2,
    MODE_WAKE  = 2'd3
  } ssby_mode_e;

  function automatic ssby_mode_e mode_of(input ssby_state_e s);
    case (s)
      ST_ENTRY:         mode_of = MODE_ENTRY;
      ST_STBY:          mode_of = MODE_STBY;
      ST_WCUT, ST_WOSC: mode_of = MODE_WAKE;
      default:          mode_of = MODE_RUN;
    endcase
  endfunction

endpackage

// File: rtl/ssby_wake_qual.sv
module ssby_wake_qual #(
  parameter int unsigned NSRC   = 8,
  parameter int unsigned PRIO_W = 4
) (
  input  logic [NSRC-1:0]        irq_req,
  input  logic [NSRC-1:0]        irq_to_cpu,
  input  logic [NSRC-1:0]        irq_en,
  input  logic [NSRC*PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0]      cpu_ipl,
  output logic                   wake_req
);

  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [PRIO_W-1:0] prio;
    assign prio   = irq_prio[g*PRIO_W +: PRIO_W];
    assign hit[g] = irq_req[g] & irq_to_cpu[g] & irq_en[g] & (prio > cpu_ipl);
  end

  assign wake_req = |hit;

endmodule

// File: rtl/ssby_seq.sv
module ssby_seq
  import ssby_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wait_stb,
  input  logic        stby_sel,
  input  logic        deep_sel,
  input  logic        osc_mon_en,
  input  logic        wake_req,
  input  logic        osc_stable,
  output ssby_state_e state_q,
  output logic        sleep_q,
  output logic        gie_q,
  output logic        chg_q
);

  ssby_state_e state_d;
  logic        sleep_d;
  logic        gie_d;
  logic        chg_d;
  logic        qualify;
  logic        state_we;
  logic        sleep_we;

  assign qualify = stby_sel & ~deep_sel & ~osc_mon_en;

  always_comb begin
    state_d = state_q;
    sleep_d = sleep_q;
    gie_d   = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (sleep_q) begin
          if (wake_req) sleep_d = 1'b0;
        end else if (wait_stb) begin
          gie_d = 1'b1;
          if (qualify) state_d = ST_ENTRY;
          else         sleep_d = 1'b1;
        end
      end
      ST_ENTRY: state_d = ST_STBY;
      ST_STBY:  if (wake_req) state_d = ST_WCUT;
      ST_WCUT:  state_d = ST_WOSC;
      ST_WOSC:  if (osc_stable) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  assign chg_d    = (mode_of(state_d) != mode_of(state_q));
  assign state_we = (state_d != state_q);
  assign sleep_we = (sleep_d != sleep_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      sleep_q <= 1'b0;
      gie_q   <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      if (state_we) state_q <= state_d;
      if (sleep_we) sleep_q <= sleep_d;
      gie_q <= gie_d;
      chg_q <= chg_d;
    end
  end

endmodule

// File: rtl/ssby_out_dec.sv
module ssby_out_dec
  import ssby_pkg::*;
#(
  parameter int unsigned NOSC = 3
) (
  input  ssby_state_e            state_q,
  input  logic                   sleep_q,
  input  logic [CUT_DOMAINS-1:0] cut_cfg,
  input  logic                   iwdg_auto,
  input  logic                   iwdg_opt_stop,
  input  logic                   iwdg_reg_stop,
  output logic                   cpu_clk_en,
  output logic                   per_clk_en,
  output logic [NOSC-1:0]        osc_en,
  output logic [CUT_DOMAINS-1:0] pwr_cut,
  output logic                   por_lowpwr,
  output logic                   iwdg_run,
  output logic [1:0]             mode
);

  logic in_run;
  logic in_stby;
  logic osc_on;
  logic stop_sel;

  assign in_run  = (state_q == ST_RUN);
  assign in_stby = (state_q == ST_STBY);
  assign osc_on  = in_run | (state_q == ST_ENTRY) | (state_q == ST_WOSC);

  assign cpu_clk_en = in_run & ~sleep_q;
  assign per_clk_en = in_run;
  assign osc_en     = {NOSC{osc_on}};

  for (genvar d = 0; d < CUT_DOMAINS; d++) begin : g_cut
    assign pwr_cut[d] = in_stby & cut_cfg[d];
  end

  assign por_lowpwr = pwr_cut[CUT_VDET];

  assign stop_sel = iwdg_auto ? iwdg_opt_stop : iwdg_reg_stop;
  assign iwdg_run = ~(in_stby & stop_sel);

  assign mode = mode_of(state_q);

endmodule

// File: rtl/ssby_ctrl.sv
module ssby_ctrl
  import ssby_pkg::*;
#(
  parameter int unsigned NSRC   = 8,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned NOSC   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wait_stb,
  input  logic                   stby_sel,
  input  logic                   deep_sel,
  input  logic                   osc_mon_en,
  input  logic [2:0]             cut_cfg,
  input  logic                   iwdg_auto,
  input  logic                   iwdg_opt_stop,
  input  logic                   iwdg_reg_stop,
  input  logic [NSRC-1:0]        irq_req,
  input  logic [NSRC-1:0]        irq_to_cpu,
  input  logic [NSRC-1:0]        irq_en,
  input  logic [NSRC*PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0]      cpu_ipl,
  input  logic                   osc_stable,
  output logic                   cpu_clk_en,
  output logic                   per_clk_en,
  output logic [NOSC-1:0]        osc_en,
  output logic [2:0]             pwr_cut,
  output logic                   por_lowpwr,
  output logic                   iwdg_run,
  output logic                   gie_set,
  output logic                   sleep_st,
  output logic [1:0]             mode,
  output logic                   mode_chg
);

  logic        rst_meta_n;
  logic        rst_sync_n;
  logic        wake_req;
  ssby_state_e state_q;
  logic        sleep_q;

  // reset asserts at once, releases after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  ssby_wake_qual #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_qual (
    .irq_req    (irq_req),
    .irq_to_cpu (irq_to_cpu),
    .irq_en     (irq_en),
    .irq_prio   (irq_prio),
    .cpu_ipl    (cpu_ipl),
    .wake_req   (wake_req)
  );

  ssby_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wait_stb   (wait_stb),
    .stby_sel   (stby_sel),
    .deep_sel   (deep_sel),
    .osc_mon_en (osc_mon_en),
    .wake_req   (wake_req),
    .osc_stable (osc_stable),
    .state_q    (state_q),
    .sleep_q    (sleep_q),
    .gie_q      (gie_set),
    .chg_q      (mode_chg)
  );

  ssby_out_dec #(.NOSC(NOSC)) u_dec (
    .state_q       (state_q),
    .sleep_q       (sleep_q),
    .cut_cfg       (cut_cfg),
    .iwdg_auto     (iwdg_auto),
    .iwdg_opt_stop (iwdg_opt_stop),
    .iwdg_reg_stop (iwdg_reg_stop),
    .cpu_clk_en    (cpu_clk_en),
    .per_clk_en    (per_clk_en),
    .osc_en        (osc_en),
    .pwr_cut       (pwr_cut),
    .por_lowpwr    (por_lowpwr),
    .iwdg_run      (iwdg_run),
    .mode          (mode)
  );

  assign sleep_st = sleep_q;

endmodule

// File: rtl/ssby_ctrl_chk.sv
module ssby_ctrl_chk #(
  parameter int unsigned NOSC = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      mode,
  input logic            mode_chg,
  input logic            cpu_clk_en,
  input logic            per_clk_en,
  input logic [NOSC-1:0] osc_en,
  input logic [2:0]      pwr_cut,
  input logic [2:0]      cut_cfg,
  input logic            por_lowpwr,
  input logic            iwdg_run,
  input logic            gie_set,
  input logic            osc_stable
);

  AST_ENTRY_TO_STBY: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd1) |=> (mode == 2'd2)); // R1
  AST_STBY_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd2) |-> (osc_en == '0 && !cpu_clk_en && !per_clk_en)); // R3
  AST_CUT_ONLY_STBY: assert property (@(posedge clk) disable iff (!rst_n) (mode != 2'd2) |-> (pwr_cut == 3'b000 && !por_lowpwr)); // R4
  AST_STBY_CUT_SEL: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd2) |-> (pwr_cut == cut_cfg)); // R4
  AST_IWDG_RUNS_AWAKE: assert property (@(posedge clk) disable iff (!rst_n) (mode != 2'd2) |-> iwdg_run); // R5
  AST_GIE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) gie_set |=> !gie_set); // R6
  AST_WAKE_CLK_HELD: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd3) |-> (!cpu_clk_en && !per_clk_en)); // R8
  AST_RUN_AFTER_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd0 && $past(mode) == 2'd3) |-> $past(osc_stable)); // R8
  AST_CHG_ON_NEW_MODE: assert property (@(posedge clk) disable iff (!rst_n) mode_chg |-> (mode != $past(mode))); // R9

endmodule

bind ssby_ctrl ssby_ctrl_chk #(.NOSC(NOSC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .mode_chg   (mode_chg),
  .cpu_clk_en (cpu_clk_en),
  .per_clk_en (per_clk_en),
  .osc_en     (osc_en),
  .pwr_cut    (pwr_cut),
  .cut_cfg    (cut_cfg),
  .por_lowpwr (por_lowpwr),
  .iwdg_run   (iwdg_run),
  .gie_set    (gie_set),
  .osc_stable (osc_stable)
);

// File: tb/ssby_ctrl_test.sv
`timescale 1ns/1ps
module ssby_ctrl_test;

  localparam int NSRC  = 8;
  localparam int PW    = 4;
  localparam int NOSC  = 3;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                 rst_n;
  logic                 wait_stb, stby_sel, deep_sel, osc_mon_en;
  logic [2:0]           cut_cfg;
  logic                 iwdg_auto, iwdg_opt_stop, iwdg_reg_stop;
  logic [NSRC-1:0]      irq_req, irq_to_cpu, irq_en;
  logic [NSRC*PW-1:0]   irq_prio;
  logic [PW-1:0]        cpu_ipl;
  logic                 osc_stable;
  logic                 cpu_clk_en, per_clk_en, por_lowpwr, iwdg_run, gie_set, sleep_st, mode_chg;
  logic [NOSC-1:0]      osc_en;
  logic [2:0]           pwr_cut;
  logic [1:0]           mode;

  ssby_ctrl #(.NSRC(NSRC), .PRIO_W(PW), .NOSC(NOSC)) uut (
    .clk(clk), .rst_n(rst_n), .wait_stb(wait_stb), .stby_sel(stby_sel),
    .deep_sel(deep_sel), .osc_mon_en(osc_mon_en), .cut_cfg(cut_cfg),
    .iwdg_auto(iwdg_auto), .iwdg_opt_stop(iwdg_opt_stop), .iwdg_reg_stop(iwdg_reg_stop),
    .irq_req(irq_req), .irq_to_cpu(irq_to_cpu), .irq_en(irq_en), .irq_prio(irq_prio),
    .cpu_ipl(cpu_ipl), .osc_stable(osc_stable), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .osc_en(osc_en), .pwr_cut(pwr_cut), .por_lowpwr(por_lowpwr),
    .iwdg_run(iwdg_run), .gie_set(gie_set), .sleep_st(sleep_st), .mode(mode), .mode_chg(mode_chg)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: phase 0 run, 1 entry, 2 standby, 3 wake (cut released), 4 wake (osc on)
  int m_ph = 0, m_rc = 0;
  bit m_sleep = 0, m_gie = 0, m_chg = 0;

  function automatic int mcode(input int ph);
    return (ph >= 3) ? 3 : ph;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rc = 0; m_ph = 0; m_sleep = 0; m_gie = 0; m_chg = 0;
    end else if (m_rc < 2) begin
      m_rc++;
    end else begin
      int  prev;
      bit  wake;
      prev = mcode(m_ph);
      wake = 0;
      for (int i = 0; i < NSRC; i++)
        if (irq_req[i] && irq_to_cpu[i] && irq_en[i] && (int'(irq_prio[i*PW +: PW]) > int'(cpu_ipl)))
          wake = 1;
      m_gie = 0;
      if (m_ph == 0) begin
        if (m_sleep) begin
          if (wake) m_sleep = 0;
        end else if (wait_stb) begin
          m_gie = 1;
          if (stby_sel && !deep_sel && !osc_mon_en) m_ph = 1;
          else m_sleep = 1;
        end
      end else if (m_ph == 1) m_ph = 2;
      else if (m_ph == 2) begin
        if (wake) m_ph = 3;
      end else if (m_ph == 3) m_ph = 4;
      else if (osc_stable) m_ph = 0;
      m_chg = (mcode(m_ph) != prev);
    end
  end

  // per-cycle comparison, 3 ns after the falling edge
  always begin
    @(negedge clk);
    #3;
    if (rst_n && !done) begin
      int stop_b;
      stop_b = iwdg_auto ? int'(iwdg_opt_stop) : int'(iwdg_reg_stop);
      chk("R1", "mode", int'(mode), mcode(m_ph));
      chk("R9", "mode_chg", int'(mode_chg), int'(m_chg));
      chk("R6", "gie_set", int'(gie_set), int'(m_gie));
      chk("R2", "sleep_st", int'(sleep_st), int'(m_sleep));
      chk("R3", "cpu_clk_en", int'(cpu_clk_en), int'(m_ph == 0 && !m_sleep));
      chk("R3", "per_clk_en", int'(per_clk_en), int'(m_ph == 0));
      chk("R3", "osc_en", int'(osc_en), (m_ph == 0 || m_ph == 1 || m_ph == 4) ? 7 : 0);
      chk("R4", "pwr_cut", int'(pwr_cut), (m_ph == 2) ? int'(cut_cfg) : 0);
      chk("R4", "por_lowpwr", int'(por_lowpwr), int'(m_ph == 2 && cut_cfg[2]));
      chk("R5", "iwdg_run", int'(iwdg_run), (m_ph == 2 && stop_b == 1) ? 0 : 1);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT && !done) begin
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=<%0d cycles", cyc, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sample();
    @(negedge clk);
    #3;
  endtask

  task automatic pulse_wait();
    @(negedge clk);
    wait_stb = 1'b1;
    @(negedge clk);
    wait_stb = 1'b0;
  endtask

  task automatic set_src(input int idx, input bit req, input bit to_cpu, input bit en, input int prio);
    irq_req[idx]    = req;
    irq_to_cpu[idx] = to_cpu;
    irq_en[idx]     = en;
    irq_prio[idx*PW +: PW] = PW'(prio);
  endtask

  task automatic clear_irq();
    irq_req = '0; irq_to_cpu = '0; irq_en = '0; irq_prio = '0;
  endtask

  initial begin
    rst_n = 1'b0; wait_stb = 0; stby_sel = 0; deep_sel = 0; osc_mon_en = 0;
    cut_cfg = 3'b000; iwdg_auto = 0; iwdg_opt_stop = 0; iwdg_reg_stop = 0;
    irq_req = '0; irq_to_cpu = '0; irq_en = '0; irq_prio = '0;
    cpu_ipl = 4'd3; osc_stable = 1'b0;

    step(3);
    sample();
    chk("R11", "reset mode", int'(mode), 0);
    chk("R11", "reset osc_en", int'(osc_en), 7);
    chk("R11", "reset cpu_clk_en", int'(cpu_clk_en), 1);
    chk("R11", "reset pwr_cut", int'(pwr_cut), 0);
    chk("R11", "reset gie_set", int'(gie_set), 0);
    @(negedge clk); rst_n = 1'b1;
    step(4);

    // A: standby entry, auto-start watchdog with option stop bit set
    stby_sel = 1; cut_cfg = 3'b101; iwdg_auto = 1; iwdg_opt_stop = 1; iwdg_reg_stop = 0;
    pulse_wait();
    #3;
    chk("R1", "mode after strobe", int'(mode), 1);
    chk("R6", "gie pulse", int'(gie_set), 1);
    sample();
    chk("R1", "mode standby", int'(mode), 2);
    chk("R5", "iwdg stopped by option bit", int'(iwdg_run), 0);
    chk("R4", "cuts", int'(pwr_cut), 5);
    // non-qualifying sources
    @(negedge clk); set_src(2, 1, 1, 1, 3);
    step(3); #3;
    chk("R7", "equal priority keeps standby", int'(mode), 2);
    @(negedge clk); set_src(2, 1, 1, 0, 9);
    step(3); #3;
    chk("R7", "disabled source keeps standby", int'(mode), 2);
    @(negedge clk); set_src(2, 1, 0, 1, 9);
    step(3); #3;
    chk("R7", "unrouted source keeps standby", int'(mode), 2);
    @(negedge clk); clear_irq();
    pulse_wait();
    sample();
    chk("R10", "strobe in standby ignored", int'(mode), 2);
    chk("R10", "no gie in standby", int'(gie_set), 0);
    // qualified wake, oscillator slow
    @(negedge clk); set_src(5, 1, 1, 1, 4);
    @(negedge clk); clear_irq();
    #3;
    chk("R8", "first wake cycle osc off", int'(osc_en), 0);
    chk("R8", "first wake cycle cuts released", int'(pwr_cut), 0);
    chk("R7", "wake mode", int'(mode), 3);
    sample();
    chk("R8", "second wake cycle osc on", int'(osc_en), 7);
    step(4); #3;
    chk("R8", "clocks held without stable", int'(cpu_clk_en), 0);
    @(negedge clk); osc_stable = 1;
    sample();
    chk("R8", "back to run", int'(mode), 0);
    chk("R8", "cpu clock restored", int'(cpu_clk_en), 1);
    @(negedge clk); osc_stable = 0;
    step(2);

    // B: monitor enabled -> sleep
    osc_mon_en = 1;
    pulse_wait();
    #3;
    chk("R2", "sleep from monitor", int'(sleep_st), 1);
    chk("R2", "osc kept", int'(osc_en), 7);
    chk("R6", "gie on sleep entry", int'(gie_set), 1);
    pulse_wait();
    #3;
    chk("R10", "strobe while sleeping", int'(gie_set), 0);
    @(negedge clk); set_src(0, 1, 1, 1, 15);
    @(negedge clk); clear_irq();
    #3;
    chk("R7", "sleep cleared by wake", int'(sleep_st), 0);
    osc_mon_en = 0;
    step(2);

    // C: deep select and standby select low
    deep_sel = 1;
    pulse_wait();
    #3;
    chk("R2", "deep select gives sleep", int'(sleep_st), 1);
    @(negedge clk); set_src(7, 1, 1, 1, 4);
    @(negedge clk); clear_irq(); deep_sel = 0; stby_sel = 0;
    step(2);
    pulse_wait();
    #3;
    chk("R2", "standby select low gives sleep", int'(sleep_st), 1);
    chk("R1", "mode stays run", int'(mode), 0);
    @(negedge clk); set_src(1, 1, 1, 1, 8);
    @(negedge clk); clear_irq(); stby_sel = 1;
    step(2);

    // D: register-start watchdog, bits opposite
    iwdg_auto = 0; iwdg_opt_stop = 1; iwdg_reg_stop = 0; cut_cfg = 3'b010;
    pulse_wait();
    step(1); #3;
    chk("R5", "register mode runs", int'(iwdg_run), 1);
    chk("R4", "por select off", int'(por_lowpwr), 0);
    @(negedge clk); iwdg_reg_stop = 1; iwdg_opt_stop = 0; cut_cfg = 3'b100;
    #3;
    chk("R5", "register mode stops", int'(iwdg_run), 0);
    chk("R4", "por select on", int'(por_lowpwr), 1);
    @(negedge clk); iwdg_auto = 1;
    #3;
    chk("R5", "auto mode opt clear runs", int'(iwdg_run), 1);
    // wake with oscillator already stable
    @(negedge clk); osc_stable = 1; set_src(3, 1, 1, 1, 12);
    @(negedge clk); clear_irq();
    #3;
    chk("R8", "stable ignored in first wake cycle", int'(mode), 3);
    sample();
    chk("R8", "second wake cycle", int'(mode), 3);
    sample();
    chk("R8", "run after stable", int'(mode), 0);
    @(negedge clk); osc_stable = 0;
    step(2);

    // E: reset during standby
    cut_cfg = 3'b111;
    pulse_wait();
    step(2);
    @(negedge clk); rst_n = 1'b0;
    #3;
    chk("R11", "async reset mode", int'(mode), 0);
    chk("R11", "async reset cuts", int'(pwr_cut), 0);
    chk("R11", "async reset osc", int'(osc_en), 7);
    step(2);
    @(negedge clk); rst_n = 1'b1;
    pulse_wait();
    #3;
    chk("R11", "strobe during release ignored", int'(mode), 0);
    step(3);
    pulse_wait();
    #3;
    chk("R11", "active after release", int'(mode), 1);
    step(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule